// File: doc/BRIEF.md
# System Bus Write Data Pacer

The pacer turns processor write requests into cycles on a multiplexed address/data system bus. Each request is either a single transfer or a cache-line block. The pacer drives one address cycle, waits a programmable number of idle clocks, and then emits the data beats. The beats are spaced by a selectable repeating data/idle pattern, so that slower memory behind the bus, such as synchronous DRAM, can keep up. The pattern, the delay and the bus width are sampled when a request is accepted and held until that request finishes.

A mode input selects a 64-bit or a 32-bit bus. In 32-bit mode a block takes twice as many beats, each carrying one word on the low half of the bus. A single write wider than a word is split into two complete transfers, each with its own address cycle. A pattern code outside the defined set raises an error flag for one cycle and puts nothing on the bus. An overlap mode lets the next request be accepted during the final data beat of the current one, which removes the idle cycle between back-to-back writes.

Top module: `wr_pacer`

## Requirements
- R1: The pattern code selects the data spacing as a group of one or two data beats followed by a run of idle cycles, repeated: code 0 = 1 data/0 idle, 1 = 2/1, 2 = 2/2, 3 = 1/1, 4 = 2/3, 5 = 2/4, 6 = 1/2, 7 = 2/6, 8 = 1/3. The period restarts at the first data beat, and no idle cycles follow the final beat.
- R2: The delay code (0 to 7) places exactly that many idle cycles between an address cycle and the first data beat of the same transfer, for single and block writes alike. With a delay of 0 the data follows the address on the next cycle.
- R3: A block write produces 4 data beats in 64-bit mode and 8 in 32-bit mode. A single write produces 1 beat per transfer. In 64-bit mode beat k carries request data bits [64k+63:64k].
- R4: In 32-bit mode (`cfgHalf`=1) beat k carries request data bits [32k+31:32k] on bus bits 31:0, with bus bits 63:32 driven to zero.
- R5: In 32-bit mode a single write with `reqWide`=1 becomes two transfers. The first uses the request address and data word 0. The second follows directly after the first data beat, with the address plus 4 and data word 1. Each transfer has its own delay.
- R6: In 64-bit mode, for a block write or a wide single write, address bits 2:0 are driven as zero in the address cycle. Otherwise the address is driven unchanged, zero-extended to 64 bits.
- R7: `busValid` is 1 only on address cycles (`busIsAddr`=1) and on data beats. On delay, idle and spacing cycles `busValid` and `busIsAddr` are 0 and `busAd` is all zero.
- R8: A request accepted with a pattern code of 9 to 15 produces no bus activity, and `errFlag` is 1 in the cycle after acceptance.
- R9: `reqReady` is 1 when the pacer is idle and `wrRdy` is 1. With `cfgOverlap`=1 it is also 1 during the final data beat of a request. An accepted legal request drives its address cycle in the next cycle.
- R10: While `wrRdy` is 0, `reqReady` stays 0 and no request is accepted.
- R11: Pattern, delay and bus width are sampled at acceptance. Changing them while a request is in flight does not alter that request's cycles.
- R12: After reset `busValid`, `busIsAddr` and `errFlag` are 0, `busAd` is zero, and `reqReady` follows `wrRdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPattern | input | 4 | Data/idle spacing code |
| cfgDelay | input | 3 | Idle cycles from address to first data |
| cfgHalf | input | 1 | 1 selects the 32-bit bus mode |
| cfgOverlap | input | 1 | 1 allows acceptance during the final data beat |
| reqValid | input | 1 | Write request present |
| reqBlock | input | 1 | 1 for a cache-line block write |
| reqWide | input | 1 | Single write wider than one word |
| reqAddr | input | 32 | Write address |
| reqData | input | 256 | Write data, doubleword 0 in the low bits |
| reqReady | output | 1 | Request accepted when high with reqValid |
| wrRdy | input | 1 | External agent can take a write |
| busAd | output | 64 | Multiplexed address/data bus |
| busValid | output | 1 | Bus carries a valid address or data |
| busIsAddr | output | 1 | Current valid cycle is an address cycle |
| errFlag | output | 1 | Illegal pattern code was rejected |

## Verification
All nine legal pattern codes are run on 64-bit blocks. Four-beat blocks show where the idle run is inserted after a pair versus after each single beat. Delays of 0, 1, 3 and 7 on single and block writes separate an off-by-one in the address-to-data gap from an error in the spacing. 32-bit blocks, wide and narrow singles in both modes, and unaligned addresses tell word selection, split addressing and low-bit masking apart. Back-to-back requests with and without overlap, a held-low write-ready, illegal codes, and a change of configuration during a transfer expose handshake and sampling mistakes.

// File: rtl/wr_pacer_pkg.sv
package wr_pacer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_GAP  = 2'd2,
    ST_DATA = 2'd3
  } pacer_state_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;    // latch a new legal request
    logic addrCycle;  // this cycle drives the address
    logic dataBeat;   // this cycle drives a data beat
    logic bumpAddr;   // move to the second half of a split write
  } pacer_strobe_t;

  // spacing decode: {two-beat group, idle run length}
  function automatic logic [3:0] spacing_of(input logic [3:0] code);
    logic [3:0] r;
    case (code)
      4'd0:    r = {1'b0, 3'd0};
      4'd1:    r = {1'b1, 3'd1};
      4'd2:    r = {1'b1, 3'd2};
      4'd3:    r = {1'b0, 3'd1};
      4'd4:    r = {1'b1, 3'd3};
      4'd5:    r = {1'b1, 3'd4};
      4'd6:    r = {1'b0, 3'd2};
      4'd7:    r = {1'b1, 3'd6};
      4'd8:    r = {1'b0, 3'd3};
      default: r = 4'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wr_pacer_ctl.sv
module wr_pacer_ctl
  import wr_pacer_pkg::*;
#(
  parameter int BLK_BEATS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    cfgPattern,
  input  logic [2:0]    cfgDelay,
  input  logic          cfgHalf,
  input  logic          cfgOverlap,
  input  logic          reqValid,
  input  logic          reqBlock,
  input  logic          reqWide,
  input  logic          wrRdy,
  output logic          reqReady,
  output logic          errFlag,
  output pacer_strobe_t strobes
);

  localparam int MAX_BEATS = 2 * BLK_BEATS;
  localparam int BW        = $clog2(MAX_BEATS + 1);

  pacer_state_e   st;
  logic [2:0]     gapCnt;
  logic [2:0]     dlySnap;
  logic [2:0]     idleSnap;
  logic           pairSnap;
  logic [3:0]     phase;
  logic [BW-1:0]  beatsLeft;
  logic           splitPend;

  logic           legal;
  logic [3:0]     pick;
  logic [3:0]     grpLen;
  logic [3:0]     periodLen;
  logic           isBeat;
  logic           lastBeat;
  logic           periodLast;
  logic           accept;
  logic [BW-1:0]  firstBeats;

  assign legal      = (cfgPattern <= 4'd8);
  assign pick       = spacing_of(cfgPattern);
  assign grpLen     = pairSnap ? 4'd2 : 4'd1;
  assign periodLen  = grpLen + {1'b0, idleSnap};
  assign isBeat     = (st == ST_DATA) && (phase < grpLen);
  assign lastBeat   = isBeat && (beatsLeft == BW'(1)) && !splitPend;
  assign periodLast = (phase == (periodLen - 4'd1));

  assign reqReady = wrRdy && ((st == ST_IDLE) || (cfgOverlap && lastBeat));
  assign accept   = reqValid && reqReady;

  always_comb begin
    if (reqBlock) firstBeats = cfgHalf ? BW'(MAX_BEATS) : BW'(BLK_BEATS);
    else          firstBeats = BW'(1);
  end

  assign strobes.capture   = accept && legal;
  assign strobes.addrCycle = (st == ST_ADDR);
  assign strobes.dataBeat  = isBeat;
  assign strobes.bumpAddr  = isBeat && (beatsLeft == BW'(1)) && splitPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      gapCnt    <= '0;
      dlySnap   <= '0;
      idleSnap  <= '0;
      pairSnap  <= 1'b0;
      phase     <= '0;
      beatsLeft <= '0;
      splitPend <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      errFlag <= accept && !legal;
      case (st)
        ST_ADDR: begin
          phase <= '0;
          if (dlySnap == 3'd0) begin
            st <= ST_DATA;
          end else begin
            st     <= ST_GAP;
            gapCnt <= dlySnap;
          end
        end
        ST_GAP: begin
          if (gapCnt == 3'd1) st <= ST_DATA;
          else                gapCnt <= gapCnt - 3'd1;
        end
        ST_DATA: begin
          phase <= periodLast ? 4'd0 : phase + 4'd1;
          if (isBeat) begin
            beatsLeft <= beatsLeft - BW'(1);
            if (beatsLeft == BW'(1)) begin
              if (splitPend) begin
                splitPend <= 1'b0;
                beatsLeft <= BW'(1);
                st        <= ST_ADDR;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
        end
        default: ;
      endcase
      // acceptance overrides the end-of-request transition
      if (accept) begin
        if (legal) begin
          st        <= ST_ADDR;
          pairSnap  <= pick[3];
          idleSnap  <= pick[2:0];
          dlySnap   <= cfgDelay;
          beatsLeft <= firstBeats;
          splitPend <= cfgHalf && !reqBlock && reqWide;
        end else begin
          st <= ST_IDLE;
        end
      end
    end
  end

  // R2: the last delay cycle is followed by data
  p_gap_ends_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_GAP && gapCnt == 3'd1) |=> (st == ST_DATA));

  // R9: a legal acceptance leads to an address cycle
  p_accept_addr_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (accept && legal) |=> (st == ST_ADDR));

  // R8: a rejected request leaves the sequencer idle
  p_err_idle_r8 : assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (st == ST_IDLE));

  // R3: beat counter never exceeds a 32-bit-mode line
  p_beats_bound_r3 : assert property (@(posedge clk) disable iff (!rstN)
    beatsLeft <= BW'(MAX_BEATS));

endmodule

// File: rtl/wr_pacer_dp.sv
module wr_pacer_dp
  import wr_pacer_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUSW      = 64,
  parameter int BLK_BEATS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pacer_strobe_t             strobes,
  input  logic                      cfgHalf,
  input  logic                      reqBlock,
  input  logic                      reqWide,
  input  logic [AW-1:0]             reqAddr,
  input  logic [BUSW*BLK_BEATS-1:0] reqData,
  output logic [BUSW-1:0]           busAd,
  output logic                      busValid,
  output logic                      busIsAddr
);

  localparam int DATAW = BUSW * BLK_BEATS;
  localparam int HALFW = BUSW / 2;
  localparam int NHALF = 2 * BLK_BEATS;
  localparam int IDXW  = $clog2(NHALF);

  logic [AW-1:0]    addrReg;
  logic [DATAW-1:0] dataReg;
  logic [IDXW-1:0]  wordIdx;
  logic             halfReg;
  logic             dwReg;

  logic [BUSW-1:0]  fullWords [BLK_BEATS];
  logic [HALFW-1:0] halfWords [NHALF];

  for (genvar i = 0; i < BLK_BEATS; i++) begin : g_full
    assign fullWords[i] = dataReg[i*BUSW +: BUSW];
  end
  for (genvar j = 0; j < NHALF; j++) begin : g_half
    assign halfWords[j] = dataReg[j*HALFW +: HALFW];
  end

  logic [AW-1:0]   addrOut;
  logic [BUSW-1:0] dataOut;

  assign addrOut = dwReg ? {addrReg[AW-1:3], 3'b000} : addrReg;
  assign dataOut = halfReg ? {{HALFW{1'b0}}, halfWords[wordIdx]}
                           : fullWords[wordIdx[IDXW-2:0]];

  always_comb begin
    if (strobes.addrCycle)     busAd = {{(BUSW-AW){1'b0}}, addrOut};
    else if (strobes.dataBeat) busAd = dataOut;
    else                       busAd = '0;
  end
  assign busValid  = strobes.addrCycle || strobes.dataBeat;
  assign busIsAddr = strobes.addrCycle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      wordIdx <= '0;
      halfReg <= 1'b0;
      dwReg   <= 1'b0;
    end else if (strobes.capture) begin
      addrReg <= reqAddr;
      dataReg <= reqData;
      wordIdx <= '0;
      halfReg <= cfgHalf;
      dwReg   <= !cfgHalf && (reqBlock || reqWide);
    end else begin
      if (strobes.dataBeat) wordIdx <= wordIdx + IDXW'(1);
      if (strobes.bumpAddr) addrReg <= addrReg + AW'(4);
    end
  end

  // R6: doubleword address cycles carry zero low bits
  p_dw_mask_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (busIsAddr && dwReg) |-> (busAd[2:0] == 3'b000));

  // R4: narrow-mode beats leave the upper half at zero
  p_half_upper_r4 : assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busIsAddr && halfReg) |-> (busAd[BUSW-1:HALFW] == '0));

  // R7: an idle bus is quiet
  p_idle_quiet_r7 : assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (busAd == '0 && !busIsAddr));

endmodule

// File: rtl/wr_pacer.sv
module wr_pacer
  import wr_pacer_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUSW      = 64,
  parameter int BLK_BEATS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [3:0]                cfgPattern,
  input  logic [2:0]                cfgDelay,
  input  logic                      cfgHalf,
  input  logic                      cfgOverlap,
  input  logic                      reqValid,
  input  logic                      reqBlock,
  input  logic                      reqWide,
  input  logic [AW-1:0]             reqAddr,
  input  logic [BUSW*BLK_BEATS-1:0] reqData,
  output logic                      reqReady,
  input  logic                      wrRdy,
  output logic [BUSW-1:0]           busAd,
  output logic                      busValid,
  output logic                      busIsAddr,
  output logic                      errFlag
);

  pacer_strobe_t strobes;

  wr_pacer_ctl #(.BLK_BEATS(BLK_BEATS)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgPattern (cfgPattern),
    .cfgDelay   (cfgDelay),
    .cfgHalf    (cfgHalf),
    .cfgOverlap (cfgOverlap),
    .reqValid   (reqValid),
    .reqBlock   (reqBlock),
    .reqWide    (reqWide),
    .wrRdy      (wrRdy),
    .reqReady   (reqReady),
    .errFlag    (errFlag),
    .strobes    (strobes)
  );

  wr_pacer_dp #(.AW(AW), .BUSW(BUSW), .BLK_BEATS(BLK_BEATS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cfgHalf   (cfgHalf),
    .reqBlock  (reqBlock),
    .reqWide   (reqWide),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .busAd     (busAd),
    .busValid  (busValid),
    .busIsAddr (busIsAddr)
  );

endmodule

// File: tb/wr_pacer_test.sv
module wr_pacer_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic [3:0]   cfgPattern;
  logic [2:0]   cfgDelay;
  logic         cfgHalf;
  logic         cfgOverlap;
  logic         reqValid;
  logic         reqBlock;
  logic         reqWide;
  logic [31:0]  reqAddr;
  logic [255:0] reqData;
  logic         reqReady;
  logic         wrRdy;
  logic [63:0]  busAd;
  logic         busValid;
  logic         busIsAddr;
  logic         errFlag;

  int nChecks = 0;
  int nFails  = 0;

  wr_pacer uut (
    .clk(clk), .rstN(rstN), .cfgPattern(cfgPattern), .cfgDelay(cfgDelay),
    .cfgHalf(cfgHalf), .cfgOverlap(cfgOverlap), .reqValid(reqValid),
    .reqBlock(reqBlock), .reqWide(reqWide), .reqAddr(reqAddr), .reqData(reqData),
    .reqReady(reqReady), .wrRdy(wrRdy), .busAd(busAd), .busValid(busValid),
    .busIsAddr(busIsAddr), .errFlag(errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        valid;
    logic        isAddr;
    logic [63:0] ad;
    logic        err;
    logic        fin;
    string       tag;
  } cyc_t;

  cyc_t model[$];
  logic lastFinal = 1'b0;

  task automatic chk(input logic ok, input string tag,
                     input logic [127:0] act, input logic [127:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic push(input logic v, input logic a, input logic [63:0] d,
                      input logic e, input logic f, input string tag);
    cyc_t c;
    c.valid = v; c.isAddr = a; c.ad = d; c.err = e; c.fin = f; c.tag = tag;
    model.push_back(c);
  endtask

  // behavioural expectation of one accepted request
  task automatic expect_req(input int code, input int dly, input logic half,
                            input logic blk, input logic wide,
                            input logic [31:0] addr, input logic [255:0] data,
                            input string tag);
    int grp, idl, nT, nB, word;
    logic [31:0] a;
    logic [63:0] d;
    if (code > 8) begin
      push(0, 0, '0, 1, 0, tag);
      return;
    end
    grp = (code == 0 || code == 3 || code == 6 || code == 8) ? 1 : 2;
    case (code)
      0: idl = 0;  1: idl = 1;  2: idl = 2;  3: idl = 1;  4: idl = 3;
      5: idl = 4;  6: idl = 2;  7: idl = 6;  default: idl = 3;
    endcase
    nT = (half && !blk && wide) ? 2 : 1;
    nB = half ? (blk ? 8 : 1) : (blk ? 4 : 1);
    word = 0;
    for (int t = 0; t < nT; t++) begin
      a = addr + 32'(4 * t);
      if (!half && (blk || wide)) a[2:0] = 3'b000;
      push(1, 1, {32'h0, a}, 0, 0, tag);
      for (int g = 0; g < dly; g++) push(0, 0, '0, 0, 0, tag);
      for (int b = 0; b < nB; b++) begin
        d = half ? {32'h0, data[32*word +: 32]} : data[64*word +: 64];
        word++;
        push(1, 0, d, 0, (t == nT-1) && (b == nB-1), tag);
        if (((b + 1) % grp == 0) && (b != nB - 1))
          for (int k = 0; k < idl; k++) push(0, 0, '0, 0, 0, tag);
      end
    end
  endtask

  // advance to the next sample point and compare against the model
  task automatic tick();
    cyc_t e;
    @(negedge clk);
    if (model.size() != 0) e = model.pop_front();
    else begin
      e.valid = 0; e.isAddr = 0; e.ad = '0; e.err = 0; e.fin = 0; e.tag = "R7";
    end
    lastFinal = e.fin;
    chk(busValid == e.valid && busIsAddr == e.isAddr && busAd == e.ad && errFlag == e.err,
        e.tag, {61'h0, busValid, busIsAddr, errFlag, busAd},
        {61'h0, e.valid, e.isAddr, e.err, e.ad});
  endtask

  function automatic logic [255:0] mkdata(input int s);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = 32'hC0DE0000 | 32'(s << 8) | 32'(i);
    return r;
  endfunction

  task automatic send(input int code, input int dly, input logic half,
                      input logic blk, input logic wide, input logic [31:0] addr,
                      input int seed, input string tag);
    logic expR;
    cfgPattern = 4'(code); cfgDelay = 3'(dly); cfgHalf = half;
    reqBlock = blk; reqWide = wide; reqAddr = addr; reqData = mkdata(seed);
    reqValid = 1'b1;
    forever begin
      #1;
      expR = wrRdy && (model.size() == 0) && (!lastFinal || cfgOverlap);
      chk(reqReady == expR, "R9", {127'h0, reqReady}, {127'h0, expR});
      if (reqReady) begin
        expect_req(code, dly, half, blk, wide, addr, mkdata(seed), tag);
        break;
      end
      tick();
    end
    tick();
    reqValid = 1'b0;
  endtask

  task automatic drain();
    while (model.size() != 0) tick();
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgPattern = 0; cfgDelay = 0; cfgHalf = 0; cfgOverlap = 0;
    reqValid = 0; reqBlock = 0; reqWide = 0; reqAddr = 0; reqData = '0; wrRdy = 1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R12: quiet bus and ready after reset
    tick();
    #1 chk(reqReady == 1'b1, "R12", {127'h0, reqReady}, 128'h1);
    wrRdy = 1'b0;
    #1 chk(reqReady == 1'b0, "R12", {127'h0, reqReady}, 128'h0);
    wrRdy = 1'b1;
    tick();

    // R1, R3: every legal spacing on 64-bit blocks
    send(0, 0, 0, 1, 0, 32'h0000_1000, 1, "R1"); drain();
    for (int c = 1; c <= 8; c++) begin
      send(c, 1, 0, 1, 0, 32'h0000_2000 + 32'(c * 32), c + 10, "R1");
      drain();
    end

    // R3, R4: 32-bit block with spacing and delay
    send(3, 2, 1, 1, 0, 32'h0000_3000, 20, "R4"); drain();
    send(0, 0, 1, 1, 0, 32'h0000_3100, 21, "R3"); drain();

    // R2: delay extremes on single and block writes
    send(0, 7, 0, 0, 0, 32'h0000_4008, 30, "R2"); drain();
    send(0, 0, 0, 0, 1, 32'h0000_4010, 31, "R2"); drain();
    send(2, 7, 0, 1, 0, 32'h0000_4020, 32, "R2"); drain();

    // R5: split of a wide single in 32-bit mode
    send(0, 3, 1, 0, 1, 32'h0000_5003, 40, "R5"); drain();
    send(6, 0, 1, 0, 1, 32'h0000_5100, 41, "R5"); drain();
    send(0, 1, 1, 0, 0, 32'h0000_5203, 42, "R4"); drain();

    // R6: low address bits in 64-bit mode
    send(0, 0, 0, 0, 1, 32'h0000_2345, 50, "R6"); drain();
    send(0, 0, 0, 1, 0, 32'h0000_6fff, 51, "R6"); drain();
    send(0, 0, 0, 0, 0, 32'h0000_2345, 52, "R6"); drain();

    // R8: illegal codes
    send(9, 0, 0, 1, 0, 32'h0000_7000, 60, "R8"); drain();
    send(15, 3, 1, 1, 0, 32'h0000_7100, 61, "R8"); drain();

    // R10: write-ready held low blocks acceptance
    wrRdy = 1'b0; reqValid = 1'b1; reqBlock = 1'b1; cfgPattern = 0; cfgDelay = 0;
    for (int i = 0; i < 4; i++) begin
      #1 chk(reqReady == 1'b0, "R10", {127'h0, reqReady}, 128'h0);
      tick();
    end
    wrRdy = 1'b1;
    send(0, 0, 0, 1, 0, 32'h0000_8000, 70, "R10"); drain();

    // R9: back-to-back without and with overlap
    cfgOverlap = 1'b0;
    send(1, 1, 0, 1, 0, 32'h0000_9000, 80, "R9");
    send(0, 0, 0, 0, 0, 32'h0000_9100, 81, "R9"); drain();
    cfgOverlap = 1'b1;
    send(1, 1, 0, 1, 0, 32'h0000_9200, 82, "R9");
    send(0, 0, 0, 0, 0, 32'h0000_9300, 83, "R9");
    send(3, 0, 1, 0, 1, 32'h0000_9400, 84, "R9");
    send(9, 0, 0, 0, 0, 32'h0000_9500, 85, "R8"); drain();
    cfgOverlap = 1'b0;

    // R11: configuration changed while a request is in flight
    send(2, 3, 0, 1, 0, 32'h0000_A000, 90, "R11");
    send(0, 0, 1, 1, 0, 32'h0000_A100, 91, "R11"); drain();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule